// File: doc/BRIEF.md
# Register Rename Stage with Free List and Branch Checkpoint

This block is the rename step of a single-issue out-of-order pipeline. It translates the 5-bit architectural register names of each instruction into 6-bit physical register names, using a map table that covers 32 architectural registers and a pool of 64 physical registers. When an instruction writes a register, the block takes a fresh physical register from a free list, points the destination's map entry at it, and reports the physical register that the destination used to name. The pipeline carries that old name to commit and hands it back through the commit input, which returns it to the free list.

Only one unresolved branch may be in flight. When a branch is renamed, the block snapshots the map table and the read position of the free list. A mispredict resolution rolls both back, so every allocation made after the branch is undone. Registers returned at commit while the branch is pending stay free. A correct resolution just drops the snapshot. Rename outputs are combinational from the current state, and an instruction is accepted in any cycle where both `in_valid` and `in_ready` are high.

Top module: `reg_rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers 32 to 63 and hands them out in ascending order.
- R2: For an accepted instruction, `out_psrc1` and `out_psrc2` give the current mappings of `in_src1` and `in_src2` in the same cycle.
- R3: An accepted instruction with `in_dst_we` high gets the register at the front of the free list on `out_pdst` and the destination's previous mapping on `out_pold`. From the next cycle on, the destination maps to `out_pdst`.
- R4: Sources read the mapping that was in place before the same instruction's destination update. An instruction that reads and writes one register sees the old name on its source.
- R5: A `commit_valid` pulse appends `commit_preg` to the back of the free list. It is handed out only after every register that was already free.
- R6: `in_ready` is low while `in_dst_we` is high and the free list is empty. A request that is not accepted changes neither the map nor the free list.
- R7: A branch (`in_is_branch`) that is accepted saves a checkpoint of the map and the free-list front. The checkpoint includes the branch's own destination update.
- R8: `br_resolve_valid` with `br_mispredict` high restores the map and the free-list front from the checkpoint. Registers committed before or in that cycle stay free.
- R9: `br_resolve_valid` with `br_mispredict` low releases the checkpoint and leaves the map and the free list as they are.
- R10: While a checkpoint is held, a second branch sees `in_ready` low. In a mispredict cycle, `in_ready` is low for every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_src1 | input | 5 | First source architectural register |
| in_src2 | input | 5 | Second source architectural register |
| in_dst | input | 5 | Destination architectural register |
| in_dst_we | input | 1 | Instruction writes `in_dst` |
| in_is_branch | input | 1 | Instruction is a branch to checkpoint |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| out_psrc1 | output | 6 | Physical name of first source |
| out_psrc2 | output | 6 | Physical name of second source |
| out_pdst | output | 6 | Newly allocated physical destination |
| out_pold | output | 6 | Previous physical mapping of destination |
| commit_valid | input | 1 | Return a physical register to the free list |
| commit_preg | input | 6 | Physical register being returned |
| br_resolve_valid | input | 1 | Pending branch resolves this cycle |
| br_mispredict | input | 1 | Resolution was a misprediction |

## Verification
A corrupted map entry shows up at once on `out_psrc1`, `out_psrc2` or `out_pold` the next time that architectural register is named. A wrong free-list pointer shows up as an unexpected `out_pdst` on the next allocation. A bad rollback shows up as a register that is not mapped, or as a duplicate allocation in the first accesses after the mispredict. The bench keeps its own map, free-list queue and checkpoint, built from the requirements. It compares every output in every cycle, so a fault surfaces within the cycle in which the affected register or list slot is next used.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int ARCH_REGS_DEFAULT = 32;
  localparam int PHYS_REGS_DEFAULT = 64;

  typedef enum logic [1:0] {
    BR_NONE    = 2'd0,
    BR_OK      = 2'd1,
    BR_RESTORE = 2'd2
  } br_action_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ENTRIES = 32,
  parameter int IW      = 5,
  parameter int DW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  input  logic [IW-1:0] rd_c_idx,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data,
  output logic [DW-1:0] rd_c_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          snap_save,
  input  logic          snap_restore
);
  logic [DW-1:0] map_q  [ENTRIES];
  logic [DW-1:0] map_d  [ENTRIES];
  logic [DW-1:0] snap_q [ENTRIES];

  assign rd_a_data = map_q[rd_a_idx];
  assign rd_b_data = map_q[rd_b_idx];
  assign rd_c_data = map_q[rd_c_idx];

  always_comb begin
    map_d = map_q;
    if (snap_restore) map_d = snap_q;
    else if (wr_en)   map_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        map_q[i]  <= DW'(i);
        snap_q[i] <= DW'(i);
      end
    end else begin
      map_q <= map_d;
      if (snap_save) snap_q <= map_d;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH = 32,
  parameter int BASE  = 32,
  parameter int DW    = 6,
  localparam int IW   = $clog2(DEPTH),
  localparam int PTRW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  output logic [DW-1:0]   front,
  output logic            empty,
  output logic [PTRW-1:0] count,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            snap_save,
  input  logic            snap_restore
);
  // DEPTH must be a power of two so the wrap bit works.
  logic [DW-1:0]   slot_q [DEPTH];
  logic [PTRW-1:0] head_q, head_d, tail_q, tail_d, snap_head_q;

  assign front = slot_q[head_q[IW-1:0]];
  assign count = tail_q - head_q;
  assign empty = (count == '0);

  always_comb begin
    head_d = head_q;
    if (snap_restore) head_d = snap_head_q;
    else if (pop)     head_d = head_q + PTRW'(1);
    tail_d = push ? tail_q + PTRW'(1) : tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      snap_head_q <= '0;
      tail_q      <= PTRW'(DEPTH);
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= DW'(BASE + i);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      if (snap_save) snap_head_q <= head_d;
      if (push) slot_q[tail_q[IW-1:0]] <= push_data;
    end
  end
endmodule

// File: rtl/reg_rename_stage.sv
module reg_rename_stage
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = ARCH_REGS_DEFAULT,
  parameter int PHYS_REGS = PHYS_REGS_DEFAULT,
  localparam int AW    = $clog2(ARCH_REGS),
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int PTRW  = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_src1,
  input  logic [AW-1:0] in_src2,
  input  logic [AW-1:0] in_dst,
  input  logic          in_dst_we,
  input  logic          in_is_branch,
  output logic          in_ready,
  output logic [PW-1:0] out_psrc1,
  output logic [PW-1:0] out_psrc2,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold,
  input  logic          commit_valid,
  input  logic [PW-1:0] commit_preg,
  input  logic          br_resolve_valid,
  input  logic          br_mispredict
);
  logic            ckpt_held_q, ckpt_held_d;
  logic            fl_empty;
  logic [PTRW-1:0] fl_count;
  logic            fire, alloc, save;
  br_action_e      br_act;

  always_comb begin
    if (!br_resolve_valid)  br_act = BR_NONE;
    else if (br_mispredict) br_act = BR_RESTORE;
    else                    br_act = BR_OK;
  end

  assign in_ready = (br_act != BR_RESTORE)
                  && !(in_dst_we && fl_empty)
                  && !(in_is_branch && ckpt_held_q);
  assign fire  = in_valid && in_ready;
  assign alloc = fire && in_dst_we;
  assign save  = fire && in_is_branch;

  always_comb begin
    ckpt_held_d = ckpt_held_q;
    if (br_act != BR_NONE) ckpt_held_d = 1'b0;
    if (save)              ckpt_held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ckpt_held_q <= 1'b0;
    else        ckpt_held_q <= ckpt_held_d;
  end

  rn_map_table #(.ENTRIES(ARCH_REGS), .IW(AW), .DW(PW)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(in_src1), .rd_b_idx(in_src2), .rd_c_idx(in_dst),
    .rd_a_data(out_psrc1), .rd_b_data(out_psrc2), .rd_c_data(out_pold),
    .wr_en(alloc), .wr_idx(in_dst), .wr_data(out_pdst),
    .snap_save(save), .snap_restore(br_act == BR_RESTORE)
  );

  rn_free_list #(.DEPTH(DEPTH), .BASE(ARCH_REGS), .DW(PW)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .front(out_pdst), .empty(fl_empty), .count(fl_count),
    .push(commit_valid), .push_data(commit_preg),
    .snap_save(save), .snap_restore(br_act == BR_RESTORE)
  );
endmodule

// File: rtl/rename_chk.sv
module rename_chk #(
  parameter int PW    = 6,
  parameter int CW    = 6,
  parameter int DEPTH = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_dst_we,
  input logic          in_is_branch,
  input logic [PW-1:0] out_pdst,
  input logic [PW-1:0] out_pold,
  input logic          commit_valid,
  input logic          br_resolve_valid,
  input logic          br_mispredict,
  input logic [CW-1:0] fl_count
);
  a_r3_new_differs_old: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dst_we) |-> (out_pdst != out_pold));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> (int'(fl_count) < DEPTH));

  a_r6_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dst_we && fl_count == '0) |-> !in_ready);

  a_r6_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !commit_valid && !br_resolve_valid)
      |=> (fl_count == $past(fl_count)));

  a_r8_restore_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve_valid && br_mispredict) |=> (fl_count >= $past(fl_count)));

  a_r10_second_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_branch) |=> !(in_is_branch && in_ready));

  a_r10_mispredict_block: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve_valid && br_mispredict) |-> !in_ready);
endmodule

bind reg_rename_stage rename_chk #(.PW(PW), .CW(PTRW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dst_we(in_dst_we), .in_is_branch(in_is_branch),
  .out_pdst(out_pdst), .out_pold(out_pold), .commit_valid(commit_valid),
  .br_resolve_valid(br_resolve_valid), .br_mispredict(br_mispredict),
  .fl_count(fl_count)
);

// File: tb/reg_rename_stage_test.sv
module reg_rename_stage_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_dst_we, in_is_branch, in_ready;
  logic [4:0] in_src1, in_src2, in_dst;
  logic [5:0] out_psrc1, out_psrc2, out_pdst, out_pold;
  logic       commit_valid, br_resolve_valid, br_mispredict;
  logic [5:0] commit_preg;

  always #4 clk = ~clk;

  reg_rename_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src1(in_src1),
    .in_src2(in_src2), .in_dst(in_dst), .in_dst_we(in_dst_we),
    .in_is_branch(in_is_branch), .in_ready(in_ready),
    .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_pdst(out_pdst),
    .out_pold(out_pold), .commit_valid(commit_valid), .commit_preg(commit_preg),
    .br_resolve_valid(br_resolve_valid), .br_mispredict(br_mispredict)
  );

  int n_checks = 0, n_errors = 0;
  int ref_map [32];
  int ck_map  [32];
  int fl      [32];
  int fh, ft, ck_fh;
  bit ck_on;
  int pend [256];
  int ph, pt, ck_pt;

  function automatic int exp_ready(bit we, bit br, bit rv, bit mp);
    return int'(!(rv && mp) && !(we && (ft - fh) == 0) && !(br && ck_on));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, then advance the model
  task automatic cyc(string tag, bit v, int s1, int s2, int d, bit we, bit br,
                     bit cv, int cp, bit rv, bit mp);
    int rdy, old;
    @(negedge clk);
    in_valid = v; in_src1 = 5'(s1); in_src2 = 5'(s2); in_dst = 5'(d);
    in_dst_we = we; in_is_branch = br; commit_valid = cv;
    commit_preg = 6'(cp); br_resolve_valid = rv; br_mispredict = mp;
    #1;
    rdy = exp_ready(we, br, rv, mp);
    chk(tag, "in_ready", int'(in_ready), rdy);
    if (v && rdy == 1) begin
      chk(tag, "psrc1", int'(out_psrc1), ref_map[s1]);
      chk(tag, "psrc2", int'(out_psrc2), ref_map[s2]);
      if (we) begin
        chk(tag, "pdst", int'(out_pdst), fl[fh % 32]);
        chk(tag, "pold", int'(out_pold), ref_map[d]);
      end
    end
    if (rv && mp) begin
      ref_map = ck_map; fh = ck_fh; pt = ck_pt; ck_on = 0;
    end else if (rv) ck_on = 0;
    if (v && rdy == 1) begin
      if (we) begin
        old = ref_map[d];
        ref_map[d] = fl[fh % 32]; fh++;
        pend[pt % 256] = old; pt++;
      end
      if (br) begin
        ck_map = ref_map; ck_fh = fh; ck_pt = pt; ck_on = 1;
      end
    end
    if (cv) begin fl[ft % 32] = cp; ft++; end
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic bit can_commit();
    return (ph < pt) && (!ck_on || ph < ck_pt);
  endfunction

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL R0 watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int cp;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin ref_map[i] = i; ck_map[i] = i; fl[i] = 32 + i; end
    fh = 0; ft = 32; ck_fh = 0; ck_on = 0; ph = 0; pt = 0; ck_pt = 0;
    rst_n = 1'b0;
    in_valid = 0; in_src1 = 0; in_src2 = 0; in_dst = 0; in_dst_we = 0;
    in_is_branch = 0; commit_valid = 0; commit_preg = 0;
    br_resolve_valid = 0; br_mispredict = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state: identity mapping, first allocation is 32
    cyc("R1", 1, 7, 31, 9, 0, 0, 0, 0, 0, 0);
    // R4 same register read and written: source sees old name 5, pdst 32
    cyc("R4", 1, 5, 5, 5, 1, 0, 0, 0, 0, 0);
    // R3 the update is visible next cycle: r5 -> 32, next pdst 33
    cyc("R3", 1, 5, 0, 6, 1, 0, 0, 0, 0, 0);

    // R6 drain the list, then a writer must stall and change nothing
    while (ft - fh > 0) cyc("R6", 1, 1, 2, int'(($urandom % 32)), 1, 0, 0, 0, 0, 0);
    cyc("R6", 1, 3, 4, 3, 1, 0, 0, 0, 0, 0);
    cyc("R6", 1, 3, 4, 0, 0, 0, 0, 0, 0, 0);

    // R5 commit returns a register that the next writer receives
    cp = pend[ph % 256]; ph++;
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, cp, 0, 0);
    cyc("R5", 1, 0, 0, 11, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      cp = pend[ph % 256]; ph++;
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, cp, 0, 0);
    end

    // R7 branch writing r12; R10 second branch blocked; then mispredict
    cyc("R7", 1, 12, 1, 12, 1, 1, 0, 0, 0, 0);
    cyc("R10", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R8", 1, 12, 13, 13, 1, 0, 0, 0, 0, 0);
    cyc("R8", 1, 13, 1, 1, 1, 0, 0, 0, 0, 0);
    cp = pend[ph % 256]; ph++;
    cyc("R10", 1, 1, 1, 1, 1, 0, 1, cp, 1, 1);
    cyc("R8", 1, 12, 13, 1, 1, 0, 0, 0, 0, 0);
    cyc("R8", 1, 1, 13, 2, 1, 0, 0, 0, 0, 0);

    // R9 correct prediction keeps later allocations
    cyc("R9", 1, 0, 0, 20, 0, 1, 0, 0, 0, 0);
    cyc("R9", 1, 20, 0, 20, 1, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R9", 1, 20, 21, 21, 1, 0, 0, 0, 0, 0);

    // R2 and all others under constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit v, we, br, cv, rv, mp;
      v  = ($urandom % 100) < 80;
      we = ($urandom % 100) < 70;
      br = ($urandom % 100) < 12;
      cv = can_commit() && (($urandom % 100) < 45);
      rv = ck_on && (($urandom % 100) < 25);
      mp = ($urandom % 2) == 1;
      cp = 0;
      if (cv) begin cp = pend[ph % 256]; ph++; end
      cyc("R2", v, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
          we, br, cv, cp, rv, mp);
    end
    idle("R2");

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule